// File: doc/BRIEF.md
# Adaptive Voltage and Frequency Controller

This block closes two nested control loops around a low-voltage logic island. The slow loop counts pulses from an on-die ring oscillator over a measurement window set by a number of reference-clock ticks. If the count falls short of a lower threshold, the silicon is slower than needed and both supply codes step up. If the count exceeds an upper threshold, the silicon has spare margin and both codes step down. A count inside the band leaves the rails alone. One code drives the logic rail regulator. The other drives the clock-distribution rail regulator, which is always kept strictly above the logic rail.

The fast loop runs on a free-running prescaler that is far shorter than the measurement window. At each decision it moves the multiplier of an all-digital PLL by one step. By default the loop probes upward. A critical-path replica raises a setup warning in any cycle where timing margin is thin. The first warning cycle in a decision period cancels the pending increase. Any further warning cycle in the same period turns the decision into a decrease. After the slow loop actually lowers the logic rail, the next frequency decision may not raise the multiplier, because the margin it would act on predates the new voltage.

All codes saturate at parameterised limits. Dropping the enable input freezes every output and restarts both loops from the start of a window and a period.

Top module: `avfs_ctrl`

## Requirements
- R1: After reset, the logic code equals LOG_MAX, the clock-rail code equals CLK_MAX and the PLL multiplier equals MULT_MIN.
- R2: A window ends on the WIN_TICKS-th reference tick since the last window end. If fewer than LO_TH oscillator pulses arrived in the window, that tick included, both rail codes rise by one, each saturating at its maximum (LOG_MAX, CLK_MAX).
- R3: A window count above HI_TH lowers the logic code by one, stopping at LOG_MIN. It lowers the clock-rail code by one only while the result stays at or above CLK_MIN and above the new logic code.
- R4: A window count from LO_TH to HI_TH inclusive leaves both rail codes unchanged.
- R5: The clock-rail code is strictly greater than the logic code at all times.
- R6: With no setup warning, the multiplier rises by one per frequency decision (one every FREQ_DIV cycles) and saturates at MULT_MAX. The first rise after reset release appears at clock edge FREQ_DIV+1. The multiplier never moves by more than one step per cycle.
- R7: A setup warning in a decision cycle blocks the increase. A single warning cycle anywhere in a decision period cancels that period's increase and leaves the multiplier unchanged.
- R8: A second or later warning cycle within one decision period makes that period's decision a one-step decrease, saturating at MULT_MIN.
- R9: A decision that actually lowers the logic code suppresses the increase at the next frequency decision.
- R10: While enable is low, all three outputs hold and oscillator, reference and warning inputs are ignored. On re-enable, a fresh window of WIN_TICKS reference ticks and a fresh decision period begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs both loops when high |
| oscPulse | input | 1 | One-cycle pulse per monitor oscillator edge, already synchronised |
| refTick | input | 1 | One-cycle pulse per reference clock period, already synchronised |
| setupWarn | input | 1 | Critical-path replica setup warning, sampled each cycle |
| logicCode | output | CODE_W | Logic rail regulator code |
| clockCode | output | CODE_W | Clock-distribution rail regulator code |
| pllMult | output | MULT_W | PLL multiplication number |

## Verification
The bench builds the controller with a four-tick window, thresholds 6 and 10, an eight-cycle frequency period and narrow code ranges: logic 3 to 6, clock rail 5 to 9, multiplier 2 to 12. A single sixteen-cycle window can therefore drive the count below, inside, at the edges of or above the hold band. A handful of windows walks the rails into both saturation limits and into the region where the clock rail's floor comes from the logic code rather than from its own minimum. The short period lets the bench count exact decision edges after reset. It can then show that a voltage decrease removes exactly one multiplier increase, and that one or several warning cycles per period give hold or decrease.

// File: rtl/avfs_pkg.sv
package avfs_pkg;

  // Registered one-cycle step requests from the control loops to the code registers.
  typedef struct packed {
    logic voltUp;
    logic voltDown;
    logic freqUp;
    logic freqDown;
  } stepStrobes_t;

endpackage

// File: rtl/avfs_sat_step.sv
module avfs_sat_step #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incEn,
  input  logic         decEn,
  input  logic [W-1:0] lowBound,
  input  logic [W-1:0] highBound,
  output logic [W-1:0] value,
  output logic [W-1:0] nextVal
);

  localparam logic [W-1:0] RST_C = W'(RESET_VAL);

  always_comb begin
    nextVal = value;
    if (incEn && (value < highBound)) begin
      nextVal = value + 1'b1;
    end else if (decEn && (value > lowBound)) begin
      nextVal = value - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= RST_C;
    end else begin
      value <= nextVal;
    end
  end

endmodule

// File: rtl/avfs_loop_ctrl.sv
module avfs_loop_ctrl
  import avfs_pkg::*;
#(
  parameter int WIN_TICKS = 2048,
  parameter int LO_TH     = 4000,
  parameter int HI_TH     = 4200,
  parameter int FREQ_DIV  = 500
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         oscPulse,
  input  logic         refTick,
  input  logic         setupWarn,
  input  logic         logicAtMin,
  output stepStrobes_t strobes
);

  localparam int REF_W    = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam int OSC_SAT  = HI_TH + 1;
  localparam int OSC_W    = $clog2(OSC_SAT + 1);
  localparam int FDIV_W   = (FREQ_DIV > 1) ? $clog2(FREQ_DIV) : 1;

  localparam logic [REF_W-1:0]  REF_LAST = REF_W'(WIN_TICKS - 1);
  localparam logic [OSC_W-1:0]  OSC_TOP  = OSC_W'(OSC_SAT);
  localparam logic [OSC_W:0]    LO_C     = (OSC_W + 1)'(LO_TH);
  localparam logic [OSC_W:0]    HI_C     = (OSC_W + 1)'(HI_TH);
  localparam logic [FDIV_W-1:0] FDIV_LAST = FDIV_W'(FREQ_DIV - 1);

  // ---------------- slow loop: oscillator measurement window ----------------
  logic [REF_W-1:0] refCnt;
  logic [OSC_W-1:0] oscCnt;
  logic [OSC_W:0]   oscSum;
  logic             winEnd;
  logic             voltUpReq;
  logic             voltDnReq;
  logic             lowersLogic;

  assign winEnd      = enable && refTick && (refCnt == REF_LAST);
  assign oscSum      = {1'b0, oscCnt} + {{OSC_W{1'b0}}, oscPulse};
  assign voltUpReq   = winEnd && (oscSum < LO_C);
  assign voltDnReq   = winEnd && (oscSum > HI_C);
  assign lowersLogic = voltDnReq && !logicAtMin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      oscCnt <= '0;
    end else if (!enable || winEnd) begin
      refCnt <= '0;
      oscCnt <= '0;
    end else begin
      if (refTick) begin
        refCnt <= refCnt + 1'b1;
      end
      if (oscPulse && (oscCnt != OSC_TOP)) begin
        oscCnt <= oscCnt + 1'b1;
      end
    end
  end

  // ---------------- fast loop: decision prescaler and warning flags ----------------
  logic [FDIV_W-1:0] freqCnt;
  logic              freqTick;
  logic              upPending;
  logic              downPending;
  logic              holdOff;
  logic              upLive;
  logic              dnLive;

  assign freqTick = enable && (freqCnt == FDIV_LAST);
  assign dnLive   = downPending || (setupWarn && !upPending);
  assign upLive   = upPending && !setupWarn && !holdOff && !dnLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqCnt <= '0;
    end else if (!enable || freqTick) begin
      freqCnt <= '0;
    end else begin
      freqCnt <= freqCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upPending   <= 1'b1;
      downPending <= 1'b0;
      holdOff     <= 1'b0;
    end else if (!enable) begin
      upPending   <= 1'b1;
      downPending <= 1'b0;
      holdOff     <= 1'b0;
    end else if (freqTick) begin
      upPending   <= 1'b1;
      downPending <= 1'b0;
      holdOff     <= lowersLogic;
    end else begin
      if (setupWarn) begin
        if (upPending) begin
          upPending <= 1'b0;
        end else begin
          downPending <= 1'b1;
        end
      end
      if (lowersLogic) begin
        holdOff <= 1'b1;
      end
    end
  end

  // ---------------- registered strobes toward the code registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobes <= '0;
    end else begin
      strobes.voltUp   <= voltUpReq;
      strobes.voltDown <= voltDnReq;
      strobes.freqUp   <= freqTick && upLive;
      strobes.freqDown <= freqTick && dnLive;
    end
  end

endmodule

// File: rtl/avfs_code_path.sv
module avfs_code_path
  import avfs_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int LOG_MIN  = 40,
  parameter int LOG_MAX  = 120,
  parameter int CLK_MIN  = 60,
  parameter int CLK_MAX  = 160,
  parameter int MULT_W   = 6,
  parameter int MULT_MIN = 4,
  parameter int MULT_MAX = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobes_t      strobes,
  output logic              logicAtMin,
  output logic [CODE_W-1:0] logicCode,
  output logic [CODE_W-1:0] clockCode,
  output logic [MULT_W-1:0] pllMult
);

  localparam logic [CODE_W-1:0] LOG_MIN_C  = CODE_W'(LOG_MIN);
  localparam logic [CODE_W-1:0] LOG_MAX_C  = CODE_W'(LOG_MAX);
  localparam logic [CODE_W-1:0] CLK_MIN_C  = CODE_W'(CLK_MIN);
  localparam logic [CODE_W-1:0] CLK_MAX_C  = CODE_W'(CLK_MAX);
  localparam logic [MULT_W-1:0] MULT_MIN_C = MULT_W'(MULT_MIN);
  localparam logic [MULT_W-1:0] MULT_MAX_C = MULT_W'(MULT_MAX);

  logic [CODE_W-1:0] logicNext;
  logic [CODE_W-1:0] clockNext;
  logic [CODE_W-1:0] clockFloor;
  logic [CODE_W-1:0] logicAbove;
  logic [MULT_W-1:0] multNext;

  assign logicAtMin = (logicCode == LOG_MIN_C);
  assign logicAbove = logicNext + 1'b1;
  assign clockFloor = (logicAbove > CLK_MIN_C) ? logicAbove : CLK_MIN_C;

  avfs_sat_step #(.W(CODE_W), .RESET_VAL(LOG_MAX)) u_logicRail (
    .clk      (clk),
    .rstN     (rstN),
    .incEn    (strobes.voltUp),
    .decEn    (strobes.voltDown),
    .lowBound (LOG_MIN_C),
    .highBound(LOG_MAX_C),
    .value    (logicCode),
    .nextVal  (logicNext)
  );

  avfs_sat_step #(.W(CODE_W), .RESET_VAL(CLK_MAX)) u_clockRail (
    .clk      (clk),
    .rstN     (rstN),
    .incEn    (strobes.voltUp),
    .decEn    (strobes.voltDown),
    .lowBound (clockFloor),
    .highBound(CLK_MAX_C),
    .value    (clockCode),
    .nextVal  (clockNext)
  );

  avfs_sat_step #(.W(MULT_W), .RESET_VAL(MULT_MIN)) u_pllMult (
    .clk      (clk),
    .rstN     (rstN),
    .incEn    (strobes.freqUp),
    .decEn    (strobes.freqDown),
    .lowBound (MULT_MIN_C),
    .highBound(MULT_MAX_C),
    .value    (pllMult),
    .nextVal  (multNext)
  );

  logic unusedNext;
  assign unusedNext = ^{clockNext, multNext};

endmodule

// File: rtl/avfs_ctrl.sv
module avfs_ctrl
  import avfs_pkg::*;
#(
  parameter int WIN_TICKS = 2048,
  parameter int LO_TH     = 4000,
  parameter int HI_TH     = 4200,
  parameter int FREQ_DIV  = 500,
  parameter int CODE_W    = 8,
  parameter int LOG_MIN   = 40,
  parameter int LOG_MAX   = 120,
  parameter int CLK_MIN   = 60,
  parameter int CLK_MAX   = 160,
  parameter int MULT_W    = 6,
  parameter int MULT_MIN  = 4,
  parameter int MULT_MAX  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              oscPulse,
  input  logic              refTick,
  input  logic              setupWarn,
  output logic [CODE_W-1:0] logicCode,
  output logic [CODE_W-1:0] clockCode,
  output logic [MULT_W-1:0] pllMult
);

  stepStrobes_t strobes;
  logic         logicAtMin;

  avfs_loop_ctrl #(
    .WIN_TICKS(WIN_TICKS),
    .LO_TH    (LO_TH),
    .HI_TH    (HI_TH),
    .FREQ_DIV (FREQ_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .oscPulse  (oscPulse),
    .refTick   (refTick),
    .setupWarn (setupWarn),
    .logicAtMin(logicAtMin),
    .strobes   (strobes)
  );

  avfs_code_path #(
    .CODE_W  (CODE_W),
    .LOG_MIN (LOG_MIN),
    .LOG_MAX (LOG_MAX),
    .CLK_MIN (CLK_MIN),
    .CLK_MAX (CLK_MAX),
    .MULT_W  (MULT_W),
    .MULT_MIN(MULT_MIN),
    .MULT_MAX(MULT_MAX)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .logicAtMin(logicAtMin),
    .logicCode (logicCode),
    .clockCode (clockCode),
    .pllMult   (pllMult)
  );

endmodule

// File: rtl/avfs_ctrl_chk.sv
module avfs_ctrl_chk #(
  parameter int CODE_W   = 8,
  parameter int LOG_MIN  = 40,
  parameter int LOG_MAX  = 120,
  parameter int CLK_MIN  = 60,
  parameter int CLK_MAX  = 160,
  parameter int MULT_W   = 6,
  parameter int MULT_MIN = 4,
  parameter int MULT_MAX = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              setupWarn,
  input logic [CODE_W-1:0] logicCode,
  input logic [CODE_W-1:0] clockCode,
  input logic [MULT_W-1:0] pllMult
);

  AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    clockCode > logicCode); // R5

  AST_LOGIC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(logicCode) >= LOG_MIN) && (int'(logicCode) <= LOG_MAX)); // R3

  AST_CLOCK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(clockCode) >= CLK_MIN) && (int'(clockCode) <= CLK_MAX)); // R2

  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pllMult) >= MULT_MIN) && (int'(pllMult) <= MULT_MAX)); // R8

  AST_MULT_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pllMult) <= int'($past(pllMult)) + 1) &&
    (int'(pllMult) + 1 >= int'($past(pllMult)))); // R6

  AST_NO_UP_ON_WARN: assert property (@(posedge clk) disable iff (!rstN)
    (pllMult > $past(pllMult)) |-> !$past(setupWarn, 2)); // R7

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable, 2) |-> ($stable(pllMult) && $stable(logicCode) && $stable(clockCode))); // R10

endmodule

bind avfs_ctrl avfs_ctrl_chk #(
  .CODE_W  (CODE_W),
  .LOG_MIN (LOG_MIN),
  .LOG_MAX (LOG_MAX),
  .CLK_MIN (CLK_MIN),
  .CLK_MAX (CLK_MAX),
  .MULT_W  (MULT_W),
  .MULT_MIN(MULT_MIN),
  .MULT_MAX(MULT_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .setupWarn(setupWarn),
  .logicCode(logicCode),
  .clockCode(clockCode),
  .pllMult  (pllMult)
);

// File: tb/sim_avfs_ctrl.sv
module sim_avfs_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_TICKS  = 4;
  localparam int LO_TH      = 6;
  localparam int HI_TH      = 10;
  localparam int FREQ_DIV   = 8;
  localparam int CODE_W     = 4;
  localparam int LOG_MIN    = 3;
  localparam int LOG_MAX    = 6;
  localparam int CLK_MIN    = 5;
  localparam int CLK_MAX    = 9;
  localparam int MULT_W     = 4;
  localparam int MULT_MIN   = 2;
  localparam int MULT_MAX   = 12;
  localparam int NVEC       = 14;

  // {oscillator pulses in window, expected logic, expected clock rail, requirement}
  localparam int VEC [NVEC][4] = '{
    '{8, 6, 9, 4},  '{3, 6, 9, 2},  '{14, 5, 8, 3}, '{16, 4, 7, 3},
    '{12, 3, 6, 3}, '{11, 3, 5, 3}, '{13, 3, 5, 3}, '{10, 3, 5, 4},
    '{6, 3, 5, 4},  '{5, 4, 6, 2},  '{0, 5, 7, 2},  '{2, 6, 8, 2},
    '{1, 6, 9, 2},  '{4, 6, 9, 2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b1;
  logic              oscPulse = 1'b0;
  logic              refTick = 1'b0;
  logic              setupWarn = 1'b0;
  logic [CODE_W-1:0] logicCode;
  logic [CODE_W-1:0] clockCode;
  logic [MULT_W-1:0] pllMult;

  int checks = 0;
  int failures = 0;
  int base;
  int multA;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  avfs_ctrl #(
    .WIN_TICKS(WIN_TICKS), .LO_TH(LO_TH), .HI_TH(HI_TH), .FREQ_DIV(FREQ_DIV),
    .CODE_W(CODE_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX),
    .CLK_MIN(CLK_MIN), .CLK_MAX(CLK_MAX),
    .MULT_W(MULT_W), .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)
  ) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .oscPulse(oscPulse),
    .refTick(refTick), .setupWarn(setupWarn),
    .logicCode(logicCode), .clockCode(clockCode), .pllMult(pllMult)
  );

  function automatic string reqName(int r);
    case (r)
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One full window: reference tick every fourth cycle, n oscillator pulses up front.
  task automatic runWindow(int n);
    for (int i = 0; i < 4 * WIN_TICKS; i++) begin
      refTick  = ((i % 4) == 3);
      oscPulse = (i < n);
      @(negedge clk);
    end
    refTick  = 1'b0;
    oscPulse = 1'b0;
    idle(3);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    enable = 1'b1;
    oscPulse = 1'b0;
    refTick = 1'b0;
    setupWarn = 1'b0;
    idle(3);
  endtask

  // Release reset at a falling edge and run 40 rising edges; optionally one high window.
  task automatic holdOffRun(bit withDown);
    doReset();
    rstN = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      oscPulse = withDown && (c <= 16);
      refTick  = withDown && (c <= 16) && ((c % 4) == 0);
      @(posedge clk);
      @(negedge clk);
    end
    oscPulse = 1'b0;
    refTick  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset values
    check(int'(logicCode) == LOG_MAX, "R1", "logicCode after reset", int'(logicCode), LOG_MAX);
    check(int'(clockCode) == CLK_MAX, "R1", "clockCode after reset", int'(clockCode), CLK_MAX);
    check(int'(pllMult) == MULT_MIN, "R1", "pllMult after reset", int'(pllMult), MULT_MIN);
    rstN = 1'b1;

    // R2 R3 R4 R5: window table
    for (int v = 0; v < NVEC; v++) begin
      runWindow(VEC[v][0]);
      check(int'(logicCode) == VEC[v][1], reqName(VEC[v][3]), "logicCode", int'(logicCode), VEC[v][1]);
      check(int'(clockCode) == VEC[v][2], reqName(VEC[v][3]), "clockCode", int'(clockCode), VEC[v][2]);
      check(clockCode > logicCode, "R5", "clock rail above logic", int'(clockCode), int'(logicCode) + 1);
    end

    // R6: multiplier saturates at its maximum with no warnings
    idle(FREQ_DIV * 12);
    check(int'(pllMult) == MULT_MAX, "R6", "pllMult saturated high", int'(pllMult), MULT_MAX);

    // R8: continuous warning walks multiplier down to its minimum
    setupWarn = 1'b1;
    idle(FREQ_DIV * 14);
    check(int'(pllMult) == MULT_MIN, "R8", "pllMult saturated low", int'(pllMult), MULT_MIN);
    setupWarn = 1'b0;
    idle(FREQ_DIV * 4);

    // R7: one warning cycle per period holds the multiplier
    for (int p = 0; p < 2; p++) begin
      setupWarn = 1'b1;
      idle(1);
      setupWarn = 1'b0;
      idle(FREQ_DIV - 1);
    end
    base = int'(pllMult);
    check(base > MULT_MIN && base < MULT_MAX, "R7", "mid-range base", base, MULT_MIN + 3);
    for (int p = 0; p < 6; p++) begin
      setupWarn = 1'b1;
      idle(1);
      setupWarn = 1'b0;
      idle(FREQ_DIV - 1);
    end
    check(int'(pllMult) == base, "R7", "pllMult held by single warnings", int'(pllMult), base);

    // R8: repeated warnings within periods step down
    setupWarn = 1'b1;
    idle(FREQ_DIV * 3);
    setupWarn = 1'b0;
    check(int'(pllMult) < base && int'(pllMult) >= base - 3, "R8", "pllMult stepped down",
          int'(pllMult), base - 2);
    idle(4);

    // R10: disabled controller ignores everything
    enable = 1'b0;
    idle(4);
    base = int'(pllMult);
    runWindow(16);
    setupWarn = 1'b1;
    idle(20);
    setupWarn = 1'b0;
    check(int'(logicCode) == LOG_MAX, "R10", "logicCode frozen", int'(logicCode), LOG_MAX);
    check(int'(clockCode) == CLK_MAX, "R10", "clockCode frozen", int'(clockCode), CLK_MAX);
    check(int'(pllMult) == base, "R10", "pllMult frozen", int'(pllMult), base);
    enable = 1'b1;
    runWindow(16);
    check(int'(logicCode) == LOG_MAX - 1, "R10", "fresh window after enable", int'(logicCode), LOG_MAX - 1);

    // R6: exact increment edges; R9: a logic decrease removes one increment
    holdOffRun(1'b0);
    multA = MULT_MIN + (40 - 1) / FREQ_DIV;
    check(int'(pllMult) == multA, "R6", "pllMult after 40 edges", int'(pllMult), multA);
    holdOffRun(1'b1);
    check(int'(logicCode) == LOG_MAX - 1, "R9", "logic lowered", int'(logicCode), LOG_MAX - 1);
    check(int'(pllMult) == multA - 1, "R9", "increment suppressed", int'(pllMult), multA - 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule